// File: doc/BRIEF.md
# Dual-Lane Polling Interval Scheduler

This block produces periodic service requests for two link lanes. There are two request kinds: a polling request and a status-read request. Each kind has its own interval timer, and both timers count ticks from one shared oscillator prescaler that divides by 64. The interval setting is a 10-bit value made of a 2-bit upper field and an 8-bit lower field. The period is 64 × (256 × upper + lower + 1) clock cycles. A setting of zero stops the timer.

Each lane has an enable bit for each request kind. A request is raised on a per-lane req/ack handshake, so a busy link can defer it. A request stays raised until it is acknowledged. Periods that elapse while a request is still pending merge into that request and are not queued. An optional stagger mode moves lane 1's polling request to one quarter of the polling interval after lane 0's. A write to either interval restarts that timer.

Top module: `lane_poll_sched`

## Requirements
- R1: While reset is held and directly after it is released, all four request outputs are low. The polling setting resets to 124 (upper 0, lower 124). The status-read setting resets to 249 (upper 0, lower 249).
- R2: With a nonzero polling setting S = {cfg_up, cfg_dn}, a polling request rises exactly 64 × (S + 1) clock edges after the edge that sampled the write. With the reset value, the request rises 8000 edges after the first edge following reset release.
- R3: The status-read timer uses the same formula with its own setting, loaded by cfg_ssr_wr. With the reset value, the first status-read request rises 16000 edges after the first edge following reset release.
- R4: A setting of zero for either kind produces no request of that kind, however long the bench waits.
- R5: A nonzero polling setting below 24 is loaded as 24 (period 1600 cycles). The status-read setting is loaded as written.
- R6: Enable bit 0 of poll_en or ssr_en governs lane 0 and bit 1 governs lane 1. A lane whose bit is low never raises that request. Clearing the bit drops a pending request at the next edge.
- R7: With stagger_en high, lane 1's polling request rises floor((S+1)/4) ticks (64 cycles each) after lane 0's. Lane 1 never fires before lane 0's first request after a restart. With stagger_en low, both lanes rise on the same edge.
- R8: A raised request stays high until the edge that samples its ack bit high. It is then low after that edge, unless a new period ends on the same edge.
- R9: Periods that end while a request is pending do not queue. A single ack clears the merged request, and the next request comes at the next period boundary.
- R10: A write to an interval setting restarts that timer and the shared prescaler from zero. The write also clears lane 1's stagger phase. The next request is timed from the write, not from the earlier schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; the prescaler divides it by 64 |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_poll_wr | input | 1 | Load {cfg_up, cfg_dn} as the polling setting and restart |
| cfg_ssr_wr | input | 1 | Load {cfg_up, cfg_dn} as the status-read setting and restart |
| cfg_up | input | 2 | Upper field of the setting being written |
| cfg_dn | input | 8 | Lower field of the setting being written |
| stagger_en | input | 1 | Place lane 1 polling a quarter interval after lane 0 |
| poll_en | input | 2 | Per-lane polling enable (bit 0 = lane 0) |
| ssr_en | input | 2 | Per-lane status-read enable (bit 0 = lane 0) |
| poll_ack | input | 2 | Per-lane polling acknowledge |
| ssr_ack | input | 2 | Per-lane status-read acknowledge |
| poll_req | output | 2 | Per-lane polling request |
| ssr_req | output | 2 | Per-lane status-read request |

## Verification
Every result has an exact timing. A request registers on the edge that ends its period, 64 × (S + 1) edges after the write edge or the reset release. A staggered lane 1 request follows 64 × floor((S+1)/4) edges after lane 0's. An ack, or a cleared enable, takes effect on the next edge. The bench counts edges from the write, or from the ack, and samples at the falling edge. It checks the edge just before each predicted rise to see the output low, and the predicted edge itself to see it high. Because a request holds until it is acknowledged, a low output after a long wait shows that no request was ever raised in that time.

// File: rtl/lps_pkg.sv
package lps_pkg;
    localparam int LANES = 2;
    typedef logic [LANES-1:0] lane_vec_t;
endpackage

// File: rtl/lps_prescaler.sv
module lps_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t q, d;

    always_comb begin
        d    = q;
        tick = (q.cnt == CW'(DIV - 1));
        if (restart)   d.cnt = '0;
        else if (tick) d.cnt = '0;
        else           d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/lps_interval_timer.sv
module lps_interval_timer #(
    parameter int SW         = 10,
    parameter int RST_SET    = 124,
    parameter int MIN_SET    = 0,
    parameter bit STAGGER_OK = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [SW-1:0] load_val,
    input  logic          stagger,
    output logic [1:0]    evt
);
    typedef struct packed {
        logic [SW-1:0] set;   // period minus one, zero = stopped
        logic [SW-1:0] cnt;   // ticks elapsed in current period
        logic          seen;  // lane 0 fired since last restart
    } tmr_t;

    tmr_t          q, d;
    logic [SW-1:0] load_set;
    logic [SW-1:0] qtr;
    logic [SW-1:0] tgt1;
    logic          live, hit0, hit1, stag_on;

    generate
        if (MIN_SET > 0) begin : g_clamp
            always_comb begin
                if (load_val != '0 && load_val < SW'(MIN_SET)) load_set = SW'(MIN_SET);
                else                                          load_set = load_val;
            end
        end else begin : g_noclamp
            assign load_set = load_val;
        end
    endgenerate

    assign stag_on = stagger & STAGGER_OK;

    always_comb begin
        d    = q;
        live = (q.set != '0);
        hit0 = live & tick & ~load & (q.cnt == q.set);
        // quarter of the period length in ticks
        qtr  = SW'(({1'b0, q.set} + (SW+1)'(1)) >> 2);
        tgt1 = (qtr == '0) ? q.set : qtr - SW'(1);
        hit1 = live & tick & ~load & (q.cnt == tgt1) & (q.seen | hit0);
        if (load) begin
            d.set  = load_set;
            d.cnt  = '0;
            d.seen = 1'b0;
        end else if (live & tick) begin
            if (hit0) begin
                d.cnt  = '0;
                d.seen = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    assign evt = {(stag_on ? hit1 : hit0), hit0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.set  <= SW'(RST_SET);
            q.cnt  <= '0;
            q.seen <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lps_req_lane.sv
module lps_req_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic en,
    input  logic ack,
    output logic req
);
    typedef struct packed {
        logic req;
    } lane_t;

    lane_t q, d;

    always_comb begin
        d     = q;
        // a new period merges into a pending request; disabling drops it
        d.req = en & (evt | (q.req & ~ack));
    end

    assign req = q.req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/lane_poll_sched.sv
module lane_poll_sched #(
    parameter int PRESC_DIV = 64,
    parameter int UP_W      = 2,
    parameter int DN_W      = 8,
    parameter int POLL_RST  = 124,
    parameter int SSR_RST   = 249,
    parameter int POLL_MIN  = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_poll_wr,
    input  logic            cfg_ssr_wr,
    input  logic [UP_W-1:0] cfg_up,
    input  logic [DN_W-1:0] cfg_dn,
    input  logic            stagger_en,
    input  logic [1:0]      poll_en,
    input  logic [1:0]      ssr_en,
    input  logic [1:0]      poll_ack,
    input  logic [1:0]      ssr_ack,
    output logic [1:0]      poll_req,
    output logic [1:0]      ssr_req
);
    import lps_pkg::*;

    localparam int SW = UP_W + DN_W;

    logic          presc_tick;
    logic [SW-1:0] wr_set;
    lane_vec_t     poll_evt, ssr_evt;

    assign wr_set = {cfg_up, cfg_dn};

    lps_prescaler #(.DIV(PRESC_DIV)) i_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_poll_wr | cfg_ssr_wr),
        .tick    (presc_tick)
    );

    lps_interval_timer #(
        .SW(SW), .RST_SET(POLL_RST), .MIN_SET(POLL_MIN), .STAGGER_OK(1'b1)
    ) i_poll_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (presc_tick),
        .load     (cfg_poll_wr),
        .load_val (wr_set),
        .stagger  (stagger_en),
        .evt      (poll_evt)
    );

    lps_interval_timer #(
        .SW(SW), .RST_SET(SSR_RST), .MIN_SET(0), .STAGGER_OK(1'b0)
    ) i_ssr_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (presc_tick),
        .load     (cfg_ssr_wr),
        .load_val (wr_set),
        .stagger  (1'b0),
        .evt      (ssr_evt)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            lps_req_lane i_poll_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .evt   (poll_evt[i]),
                .en    (poll_en[i]),
                .ack   (poll_ack[i]),
                .req   (poll_req[i])
            );
            lps_req_lane i_ssr_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .evt   (ssr_evt[i]),
                .en    (ssr_en[i]),
                .ack   (ssr_ack[i]),
                .req   (ssr_req[i])
            );
        end
    endgenerate
endmodule

// File: rtl/lps_checker.sv
module lps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] poll_en,
    input logic [1:0] ssr_en,
    input logic [1:0] poll_ack,
    input logic [1:0] ssr_ack,
    input logic [1:0] poll_req,
    input logic [1:0] ssr_req,
    input logic       tick
);
    generate
        for (genvar i = 0; i < 2; i++) begin : g_chk
            a_r8_poll_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (poll_req[i] && !poll_ack[i] && poll_en[i]) |=> poll_req[i]);
            a_r8_ssr_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (ssr_req[i] && !ssr_ack[i] && ssr_en[i]) |=> ssr_req[i]);
            a_r6_poll_off: assert property (@(posedge clk) disable iff (!rst_n)
                !poll_en[i] |=> !poll_req[i]);
            a_r6_ssr_off: assert property (@(posedge clk) disable iff (!rst_n)
                !ssr_en[i] |=> !ssr_req[i]);
            a_r2_poll_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(poll_req[i]) |-> $past(tick));
            a_r3_ssr_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ssr_req[i]) |-> $past(tick));
        end
    endgenerate
endmodule

bind lane_poll_sched lps_checker i_lps_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .poll_en  (poll_en),
    .ssr_en   (ssr_en),
    .poll_ack (poll_ack),
    .ssr_ack  (ssr_ack),
    .poll_req (poll_req),
    .ssr_req  (ssr_req),
    .tick     (presc_tick)
);

// File: tb/test_lane_poll_sched.sv
module test_lane_poll_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_poll_wr = 1'b0, cfg_ssr_wr = 1'b0;
    logic [1:0] cfg_up = '0;
    logic [7:0] cfg_dn = '0;
    logic       stagger_en = 1'b0;
    logic [1:0] poll_en = 2'b11, ssr_en = 2'b11;
    logic [1:0] poll_ack = '0, ssr_ack = '0;
    logic [1:0] poll_req, ssr_req;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lane_poll_sched i_lane_poll_sched (
        .clk(clk), .rst_n(rst_n), .cfg_poll_wr(cfg_poll_wr), .cfg_ssr_wr(cfg_ssr_wr),
        .cfg_up(cfg_up), .cfg_dn(cfg_dn), .stagger_en(stagger_en),
        .poll_en(poll_en), .ssr_en(ssr_en), .poll_ack(poll_ack), .ssr_ack(ssr_ack),
        .poll_req(poll_req), .ssr_req(ssr_req)
    );

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // write a setting; acks clear stale requests on the same edge
    task automatic wr(bit ssr, logic [9:0] val);
        cfg_up = val[9:8];
        cfg_dn = val[7:0];
        cfg_poll_wr = !ssr;
        cfg_ssr_wr  = ssr;
        poll_ack = 2'b11;
        ssr_ack  = 2'b11;
        @(posedge clk);
        @(negedge clk);
        cfg_poll_wr = 1'b0;
        cfg_ssr_wr  = 1'b0;
        poll_ack = '0;
        ssr_ack  = '0;
    endtask

    task automatic t_reset;
        chk("R1 poll during reset", poll_req, 2'b00);
        chk("R1 ssr during reset", ssr_req, 2'b00);
        rst_n = 1'b1;
        chk("R1 poll after release", poll_req, 2'b00);
        step(7999);
        chk("R2 default poll not yet", poll_req, 2'b00);
        step(1);
        chk("R2 default poll at 8000", poll_req, 2'b11);
        step(7999);
        chk("R3 default ssr not yet", ssr_req, 2'b00);
        step(1);
        chk("R3 default ssr at 16000", ssr_req, 2'b11);
    endtask

    task automatic t_interval;
        poll_en = 2'b11; ssr_en = 2'b00;
        wr(1'b0, 10'd30);
        step(1983);
        chk("R2 S=30 not yet", poll_req, 2'b00);
        step(1);
        chk("R2 S=30 at 1984", poll_req, 2'b11);
        wr(1'b0, {2'd1, 8'd0});
        step(16447);
        chk("R2 upper field not yet", poll_req, 2'b00);
        step(1);
        chk("R2 upper field at 16448", poll_req, 2'b11);
    endtask

    task automatic t_ssr;
        poll_en = 2'b00; ssr_en = 2'b10;
        wr(1'b1, 10'd9);
        step(639);
        chk("R3 ssr S=9 not yet", ssr_req, 2'b00);
        step(1);
        chk("R3 ssr S=9 lane1 only", ssr_req, 2'b10);
        chk("R6 poll disabled stays low", poll_req, 2'b00);
        ssr_en = 2'b00;
        step(1);
        chk("R6 ssr pending dropped", ssr_req, 2'b00);
    endtask

    task automatic t_zero;
        poll_en = 2'b11; ssr_en = 2'b11;
        wr(1'b1, 10'd0);
        wr(1'b0, 10'd0);
        step(20000);
        chk("R4 zero poll silent", poll_req, 2'b00);
        chk("R4 zero ssr silent", ssr_req, 2'b00);
        ssr_en = 2'b00;
    endtask

    task automatic t_clamp;
        poll_en = 2'b11;
        wr(1'b0, 10'd5);
        step(1599);
        chk("R5 clamp not yet", poll_req, 2'b00);
        step(1);
        chk("R5 clamped to 24", poll_req, 2'b11);
    endtask

    task automatic t_enable;
        poll_en = 2'b01;
        wr(1'b0, 10'd24);
        step(1599);
        chk("R6 lane0 only not yet", poll_req, 2'b00);
        step(1);
        chk("R6 lane0 only", poll_req, 2'b01);
        poll_en = 2'b00;
        step(1);
        chk("R6 disable drops pending", poll_req, 2'b00);
    endtask

    task automatic t_stagger;
        poll_en = 2'b11; stagger_en = 1'b1;
        wr(1'b0, 10'd24);
        step(1599);
        chk("R7 nothing before lane0", poll_req, 2'b00);
        step(1);
        chk("R7 lane0 first", poll_req, 2'b01);
        step(383);
        chk("R7 lane1 not yet", poll_req, 2'b01);
        step(1);
        chk("R7 lane1 quarter later", poll_req, 2'b11);
        stagger_en = 1'b0;
    endtask

    task automatic t_merge;
        poll_en = 2'b01;
        wr(1'b0, 10'd24);
        step(1600);
        chk("R8 raised", poll_req, 2'b01);
        step(1610);
        chk("R8 held without ack", poll_req, 2'b01);
        poll_ack = 2'b01;
        step(1);
        poll_ack = 2'b00;
        chk("R9 one ack clears merged", poll_req, 2'b00);
        step(1588);
        chk("R9 no queued request", poll_req, 2'b00);
        step(1);
        chk("R9 next boundary", poll_req, 2'b01);
    endtask

    task automatic t_restart;
        poll_en = 2'b01;
        wr(1'b0, 10'd24);
        step(1000);
        wr(1'b0, 10'd24);
        step(1599);
        chk("R10 old schedule gone", poll_req, 2'b00);
        step(1);
        chk("R10 timed from rewrite", poll_req, 2'b01);
    endtask

    initial begin
        step(4);
        t_reset();
        t_interval();
        t_ssr();
        t_zero();
        t_clamp();
        t_enable();
        t_stagger();
        t_merge();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule